// File: doc/BRIEF.md
# Next-Fetch-Block Predictor

This block sits at the front of an instruction-fetch pipeline. Each cycle it takes the address of the block being fetched and returns a guess for the next block to fetch. It uses only the address, so the guess is ready before any instruction byte is decoded. Addresses are grouped into 64-byte fetch blocks. A table entry links one fetch block to the block that follows it after a taken branch. It does not record the target of any single branch inside that block. If the table has no entry for the block, the guess is the next sequential block.

Later pipeline stages report each resolved branch on an update port. A report carries the fetch-block address, the taken/not-taken outcome and the target address. A taken outcome writes or rewrites an entry. A not-taken outcome removes any entry that matches and otherwise has no effect. The table is set-associative and indexed by block-address bits. It has a partial tag per way, a valid bit per way and a pseudo-LRU tree per set. The default size is 1024 sets of 4 ways, which gives 4096 entries. Once more blocks with taken branches are live than the table can hold, lookups start to miss.

Top module: `nbp_top`

## Requirements
- R1: After reset the table holds no entries, `pred_hit` is 0, and every lookup misses until a taken update is written.
- R2: A lookup that misses sets `pred_hit` to 0 one cycle later. `pred_addr` is then the looked-up address with bits [5:0] cleared, plus 64.
- R3: A taken update writes an entry. A later lookup of that block sets `pred_hit` to 1 in the next cycle, with `pred_addr` equal to the update target with bits [5:0] cleared.
- R4: Only address bits [ADDR_W-1:6] select an entry. Any byte offset in bits [5:0] of the same 64-byte block finds the same entry. The set index is bits [6+IDX_W-1:6] and the tag is the TAG_W bits directly above the index.
- R5: A not-taken update removes a matching entry, so the next lookup of that block misses. A not-taken update with no matching entry changes nothing.
- R6: When a lookup and an update occur in the same cycle, the lookup sees the table contents from before the update. The write is visible from the next cycle onward.
- R7: An allocation takes the lowest-numbered invalid way of the set first. A set therefore holds WAYS blocks with different tags at once.
- R8: When a set is full, an allocation replaces the way chosen by a binary pseudo-LRU tree. Every allocation, rewrite and lookup hit marks its way as most recently used.
- R9: A taken update for a block that already has an entry rewrites that entry's target. It does not create a second copy.
- R10: Asserting `flush` for one cycle invalidates every entry. Lookups in the following cycles miss. A lookup in the flush cycle itself still sees the old contents.
- R11: In a cycle with `fetch_valid` low, `pred_hit` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries at the next edge |
| fetch_valid | input | 1 | A lookup is requested this cycle |
| fetch_addr | input | ADDR_W | Address of the block being fetched |
| pred_hit | output | 1 | Registered: the previous lookup found an entry |
| pred_addr | output | ADDR_W | Registered: the predicted next-fetch address |
| upd_valid | input | 1 | A resolved-branch report is present |
| upd_addr | input | ADDR_W | Fetch-block address of the resolved branch |
| upd_taken | input | 1 | 1 if the branch was taken |
| upd_target | input | ADDR_W | Resolved branch target |

## Verification
The hardest case to reach from the ports is an eviction. To reach it, one set must be full and its recency tree must be in a known state. The bench first flushes the table. It then makes four allocations into a single set, which sets every node of the tree no matter what the table held before. A fifth tag then has one replacement choice that can be worked out by hand, and the bench checks that outcome. The bench then repeats the scenario with an extra lookup hit inserted before the fifth tag, which moves the victim to a different way. The capacity sweep runs on a small configuration with 4 sets of 4 ways. It fills every entry, reads each one back, and then confirms that a flush empties the whole table.

// File: rtl/nbp_pkg.sv
package nbp_pkg;
  localparam int BLK_OFS = 6;

  typedef enum logic [1:0] {
    ACT_NONE     = 2'd0,
    ACT_RETARGET = 2'd1,
    ACT_ALLOC    = 2'd2,
    ACT_DROP     = 2'd3
  } upd_act_e;
endpackage

// File: rtl/nbp_plru.sv
module nbp_plru #(
  parameter int WAYS = 4,
  localparam int LW = $clog2(WAYS)
) (
  input  logic [WAYS-1:0] bits_in,
  input  logic            touch_en,
  input  logic [LW-1:0]   touch_way,
  output logic [WAYS-1:0] bits_out,
  output logic [LW-1:0]   victim
);
  // heap-ordered tree: node n has children 2n and 2n+1, leaves at WAYS..2*WAYS-1
  always_comb begin
    int node;
    node = 1;
    for (int l = 0; l < LW; l++) node = 2 * node + int'(bits_in[node]);
    victim = LW'(node - WAYS);
  end

  always_comb begin
    int node;
    bits_out = bits_in;
    node = 1;
    if (touch_en) begin
      for (int l = 0; l < LW; l++) begin
        bits_out[node] = ~touch_way[LW-1-l];
        node = 2 * node + int'(touch_way[LW-1-l]);
      end
    end
  end
endmodule

// File: rtl/nbp_match.sv
module nbp_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 12,
  localparam int LW = $clog2(WAYS)
) (
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [WAYS-1:0]       vlds,
  input  logic [TAG_W-1:0]      key,
  output logic                  hit,
  output logic [LW-1:0]         way
);
  always_comb begin
    hit = 1'b0;
    way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!hit && vlds[w] && tags[w*TAG_W +: TAG_W] == key) begin
        hit = 1'b1;
        way = LW'(w);
      end
    end
  end
endmodule

// File: rtl/nbp_top.sv
module nbp_top
  import nbp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SETS   = 1024,
  parameter int WAYS   = 4,
  parameter int TAG_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              pred_hit,
  output logic [ADDR_W-1:0] pred_addr,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target
);
  localparam int IDX_W = $clog2(SETS);
  localparam int LW    = $clog2(WAYS);
  localparam int BLK_W = ADDR_W - BLK_OFS;
  localparam int TAG_LO = BLK_OFS + IDX_W;

  logic [TAG_W-1:0] tag_q [WAYS][SETS];
  logic [BLK_W-1:0] tgt_q [WAYS][SETS];
  logic [SETS-1:0]  vld_q [WAYS];
  logic [WAYS-1:0]  lru_q [SETS];

  logic [IDX_W-1:0] fidx, uidx;
  logic [TAG_W-1:0] ftag, utag;
  logic [BLK_W-1:0] fblk;
  assign fidx = fetch_addr[BLK_OFS +: IDX_W];
  assign ftag = fetch_addr[TAG_LO +: TAG_W];
  assign fblk = fetch_addr[ADDR_W-1:BLK_OFS];
  assign uidx = upd_addr[BLK_OFS +: IDX_W];
  assign utag = upd_addr[TAG_LO +: TAG_W];

  logic unused_bits;
  assign unused_bits = ^{upd_addr, upd_target[BLK_OFS-1:0]};

  logic [WAYS*TAG_W-1:0] l_tags, u_tags;
  logic [WAYS-1:0]       l_vld, u_vld;

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign l_tags[g*TAG_W +: TAG_W] = tag_q[g][fidx];
    assign u_tags[g*TAG_W +: TAG_W] = tag_q[g][uidx];
    assign l_vld[g] = vld_q[g][fidx];
    assign u_vld[g] = vld_q[g][uidx];
  end

  logic          l_hit, u_hit;
  logic [LW-1:0] l_way, u_way;

  nbp_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lmatch (
    .tags(l_tags), .vlds(l_vld), .key(ftag), .hit(l_hit), .way(l_way));
  nbp_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_umatch (
    .tags(u_tags), .vlds(u_vld), .key(utag), .hit(u_hit), .way(u_way));

  // update decision
  upd_act_e act;
  always_comb begin
    act = ACT_NONE;
    if (upd_valid && !flush) begin
      if (upd_taken) act = u_hit ? ACT_RETARGET : ACT_ALLOC;
      else if (u_hit) act = ACT_DROP;
    end
  end

  logic          free_any;
  logic [LW-1:0] free_way;
  always_comb begin
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!u_vld[w]) begin
        free_any = 1'b1;
        free_way = LW'(w);
      end
    end
  end

  // recency: lookup hit first, then the update touch on top of it
  logic            l_touch, u_touch;
  logic [WAYS-1:0] a_out, b_base, b_out;
  logic [LW-1:0]   a_victim, b_victim, wr_way;

  assign l_touch = fetch_valid && l_hit;
  assign u_touch = (act == ACT_RETARGET) || (act == ACT_ALLOC);
  assign b_base  = (l_touch && fidx == uidx) ? a_out : lru_q[uidx];

  always_comb begin
    if (act == ACT_ALLOC) wr_way = free_any ? free_way : b_victim;
    else                  wr_way = u_way;
  end

  nbp_plru #(.WAYS(WAYS)) u_lru_look (
    .bits_in(lru_q[fidx]), .touch_en(l_touch), .touch_way(l_way),
    .bits_out(a_out), .victim(a_victim));
  nbp_plru #(.WAYS(WAYS)) u_lru_upd (
    .bits_in(b_base), .touch_en(u_touch), .touch_way(wr_way),
    .bits_out(b_out), .victim(b_victim));

  logic unused_victim;
  assign unused_victim = ^a_victim;

  // storage: no reset so tag and target arrays can map to block RAM
  always_ff @(posedge clk) begin
    if (u_touch) begin
      tag_q[wr_way][uidx] <= utag;
      tgt_q[wr_way][uidx] <= upd_target[ADDR_W-1:BLK_OFS];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int w = 0; w < WAYS; w++) vld_q[w] <= '0;
    end else if (act == ACT_ALLOC) begin
      vld_q[wr_way][uidx] <= 1'b1;
    end else if (act == ACT_DROP) begin
      vld_q[u_way][uidx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) lru_q[s] <= '0;
    end else begin
      if (l_touch) lru_q[fidx] <= a_out;
      if (u_touch) lru_q[uidx] <= b_out;
    end
  end

  // registered prediction
  always_ff @(posedge clk) begin
    if (rst) begin
      pred_hit  <= 1'b0;
      pred_addr <= '0;
    end else begin
      pred_hit  <= fetch_valid && l_hit;
      pred_addr <= l_hit ? {tgt_q[l_way][fidx], {BLK_OFS{1'b0}}}
                         : {fblk + 1'b1, {BLK_OFS{1'b0}}};
    end
  end
endmodule

// File: rtl/nbp_checker.sv
module nbp_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              pred_hit,
  input logic [ADDR_W-1:0] pred_addr,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_addr,
  input logic              upd_taken,
  input logic [ADDR_W-1:0] upd_target
);
  AST_IDLE_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> !pred_hit); // R11

  AST_MISS_NEXT_BLOCK: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> (pred_hit ||
      pred_addr == {$past(fetch_addr[ADDR_W-1:6]) + 1'b1, 6'b0})); // R2

  AST_EMPTY_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && fetch_valid) |=> !pred_hit); // R1

  AST_EMPTY_AFTER_FLUSH: assert property (@(posedge clk) disable iff (rst)
    ($past(flush) && fetch_valid) |=> !pred_hit); // R10

  AST_TAKEN_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_taken && !flush) ##1
    (fetch_valid && fetch_addr[ADDR_W-1:6] == $past(upd_addr[ADDR_W-1:6]))
    |=> (pred_hit && pred_addr == {$past(upd_target[ADDR_W-1:6], 2), 6'b0})); // R3

  AST_NOT_TAKEN_DROPS: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_taken) ##1
    (fetch_valid && fetch_addr[ADDR_W-1:6] == $past(upd_addr[ADDR_W-1:6]))
    |=> !pred_hit); // R5
endmodule

bind nbp_top nbp_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/nbp_top_test.sv
module nbp_top_test;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          flush = 1'b0;
  logic          fetch_valid = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic          pred_hit;
  logic [AW-1:0] pred_addr;
  logic          upd_valid = 1'b0;
  logic [AW-1:0] upd_addr = '0;
  logic          upd_taken = 1'b0;
  logic [AW-1:0] upd_target = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  nbp_top #(.ADDR_W(AW), .SETS(4), .WAYS(4), .TAG_W(4)) uut (.*);

  always #5 clk = ~clk;

  // 4 sets (bits 7:6), 4-bit tag (bits 11:8)
  function automatic logic [AW-1:0] mk(int s, int t, int off);
    return AW'((t << 8) | (s << 6) | off);
  endfunction
  function automatic logic [AW-1:0] tg(int s, int t);
    return AW'(16'h8000 + s * 1024 + t * 64 + 13);
  endfunction

  task automatic check(bit ok, string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic update(logic [AW-1:0] a, bit tk, logic [AW-1:0] t);
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = a; upd_taken = tk; upd_target = t;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic lookup(logic [AW-1:0] a, bit eh, logic [AW-1:0] et, string req);
    logic [AW-1:0] exp;
    @(negedge clk);
    fetch_valid = 1'b1; fetch_addr = a;
    @(negedge clk);
    fetch_valid = 1'b0;
    exp = eh ? {et[AW-1:6], 6'b0} : AW'(((a >> 6) + 1) << 6);
    check(pred_hit == eh, req, AW'(pred_hit), AW'(eh));
    check(pred_addr == exp, req, pred_addr, exp);
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check(pred_hit == 1'b0, "R1 reset hit", AW'(pred_hit), '0);
    for (int s = 0; s < 4; s++) lookup(mk(s, s, 5), 0, '0, "R1 R2 empty miss");

    // R3 write then hit
    update(mk(0, 1, 0), 1, tg(0, 1));
    lookup(mk(0, 1, 0), 1, tg(0, 1), "R3 taken hit");
    @(negedge clk);
    check(pred_hit == 1'b0, "R11 idle", AW'(pred_hit), '0);
    // R4 other offsets of the block
    lookup(mk(0, 1, 37), 1, tg(0, 1), "R4 offset alias");
    lookup(mk(0, 1, 63), 1, tg(0, 1), "R4 offset alias");
    lookup(mk(1, 1, 0), 0, '0, "R4 other set");
    lookup(mk(0, 2, 0), 0, '0, "R4 other tag");

    // R6 same-cycle update and lookup
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = mk(1, 2, 0); upd_taken = 1'b1; upd_target = tg(1, 2);
    fetch_valid = 1'b1; fetch_addr = mk(1, 2, 9);
    @(negedge clk);
    upd_valid = 1'b0; fetch_valid = 1'b0;
    check(pred_hit == 1'b0, "R6 old contents", AW'(pred_hit), '0);
    lookup(mk(1, 2, 9), 1, tg(1, 2), "R6 visible next");

    // R5 not-taken
    update(mk(2, 3, 0), 0, tg(2, 3));
    lookup(mk(2, 3, 0), 0, '0, "R5 no alloc");
    lookup(mk(0, 1, 0), 1, tg(0, 1), "R5 unrelated kept");
    update(mk(0, 1, 0), 0, '0);
    lookup(mk(0, 1, 0), 0, '0, "R5 drop");
    lookup(mk(1, 2, 0), 1, tg(1, 2), "R5 other kept");

    // R9 retarget without duplicate
    update(mk(3, 0, 0), 1, tg(3, 0));
    update(mk(3, 0, 0), 1, tg(3, 9));
    lookup(mk(3, 0, 0), 1, tg(3, 9), "R9 new target");
    for (int t = 1; t < 4; t++) update(mk(3, t, 0), 1, tg(3, t));
    lookup(mk(3, 0, 0), 1, tg(3, 9), "R9 no duplicate");
    for (int t = 1; t < 4; t++) lookup(mk(3, t, 0), 1, tg(3, t), "R9 set full");

    // R7/R8 eviction order
    do_flush();
    for (int t = 0; t < 4; t++) update(mk(0, t, 0), 1, tg(0, t));
    update(mk(0, 4, 0), 1, tg(0, 4));
    lookup(mk(0, 0, 0), 0, '0, "R8 lru evicted");
    for (int t = 1; t < 5; t++) lookup(mk(0, t, 0), 1, tg(0, t), "R7 R8 survivors");

    for (int t = 0; t < 4; t++) update(mk(1, t, 0), 1, tg(1, t));
    lookup(mk(1, 0, 0), 1, tg(1, 0), "R8 refresh");
    update(mk(1, 4, 0), 1, tg(1, 4));
    lookup(mk(1, 2, 0), 0, '0, "R8 victim after refresh");
    lookup(mk(1, 0, 0), 1, tg(1, 0), "R8 refreshed kept");
    lookup(mk(1, 4, 0), 1, tg(1, 4), "R8 new entry");

    // R7 full capacity sweep, then R10 flush
    do_flush();
    for (int s = 0; s < 4; s++)
      for (int t = 8; t < 12; t++) update(mk(s, t, 0), 1, tg(s, t));
    for (int s = 0; s < 4; s++)
      for (int t = 8; t < 12; t++) lookup(mk(s, t, 3), 1, tg(s, t), "R7 sweep");
    do_flush();
    for (int s = 0; s < 4; s++)
      for (int t = 8; t < 12; t++) lookup(mk(s, t, 0), 0, '0, "R10 flushed");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule